// File: doc/BRIEF.md
# Dual-Channel Disk Host Register Bank

This block is the register file of a two-channel disk host controller. It decodes a 512-byte, little-endian register window behind a simple read/write port. Each request carries an address, write data, a write flag and an access size. For each channel it holds these registers:

- a bus-master command byte
- a bus-master status byte, which mixes engine-owned, software-writable and write-one-to-clear bits
- a six-bit software scratch byte
- a twelve-bit link-control word
- a masked interrupt-enable field
- a read-only configuration/status word that carries the channel's interrupt flag

Two packed summary words gather both channels' command, status and interrupt bits. Software can then poll one location instead of several.

The interrupt level of each channel is sampled into its flag. A single interrupt output is the OR of the two flags. A write to a link-control word with bit 0 set sends a one-cycle reset pulse to that channel's device bus. Both pulses also fire once as the block leaves reset. The task-file and data ports, the DMA engine and configuration space belong to other blocks. Any offset the bank does not map reads as zero and ignores writes. The DMA engine reports to the bank through an activity level and through set strobes for two status bits.

Top module: `dcsc_regbank`

## Requirements
- R1: After reset the command, status, scratch, link-control and interrupt-enable registers are zero. The read data and the interrupt output are zero. Each configuration/status word reads 0x65150000. On the first clock after reset release, both bus-reset outputs pulse high for one cycle.
- R2: The channel 0 command, scratch and status bytes read at offsets 0x00, 0x01 and 0x02. The channel 1 bytes read at 0x08, 0x09 and 0x0A. Offsets 0x03 and 0x0B read zero.
- R3: Channel 0 writes to 0x10, 0x11 and 0x12 have the same effect as writes to 0x00, 0x01 and 0x02. Channel 1 writes to 0x18, 0x19 and 0x1A have the same effect as writes to 0x08, 0x09 and 0x0A.
- R4: A status write works bit by bit. Bits 6 and 5 load the written value. Bits 2 and 1 clear where the written bit is 1. All other bits read zero. Bit 0 ignores writes and follows the channel's engine-activity input one clock later. The engine set strobe (strobe bit 0 for status bit 1, strobe bit 1 for status bit 2) sets its bit and wins over a clear in the same clock.
- R5: A write to the scratch byte keeps the low 6 bits, and bits 7:6 read zero.
- R6: A read of 0x10 returns a 32-bit word with these fields: bits 7:0 hold the channel 0 command byte, with channel 0's flag ORed into bit 4 and channel 1's flag ORed into bit 6. Bit 14 is channel 1 status bit 2. Bits 23:16 hold the channel 0 status and bits 31:24 the channel 1 status.
- R7: A read of 0x18 returns the channel 1 command byte with channel 1's flag ORed into bit 4, and the channel 1 status in bits 23:16.
- R8: The configuration/status words read at 0xA0 (channel 0) and 0xE0 (channel 1). Bit 11 is the channel's interrupt flag, which equals its interrupt-level input sampled one clock earlier. Writes to these words have no effect.
- R9: The interrupt output is the OR of the two channel flags.
- R10: The link-control word is at 0x100 (channel 0) and 0x180 (channel 1). It keeps bits 11:0 of a write. A write with bit 0 set drives that channel's bus-reset output high for exactly the next clock.
- R11: The interrupt-enable field is at 0x148 (channel 0) and 0x1C8 (channel 1). It stores write bits 31:16 ANDed with 0x3EED and reads back in bits 31:16.
- R12: A read at 0x104 (channel 0) or 0x184 (channel 1) returns 0x113 when that channel's device-present input is high, and 0 otherwise.
- R13: Every other offset reads zero. A write to any other offset changes no register and pulses no bus reset.
- R14: Read data appears on the clock after the read request and holds until the next read. It is trimmed by the size code: 0 keeps bits 7:0, 1 keeps bits 15:0, and 2 or 3 keeps all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset in the register window |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2/3 word |
| req_wdata | input | 32 | Write data |
| irq_level | input | 2 | Per-channel interrupt level |
| dev_present | input | 2 | Per-channel device-present indication |
| eng_active | input | 2 | Per-channel DMA engine activity level |
| eng_set | input | 4 | Status set strobes, two per channel (channel c uses bits 2c+1:2c) |
| rd_data | output | 32 | Registered read data |
| bus_reset | output | 2 | Per-channel one-cycle bus reset pulse |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: a 9-bit window, a 12-bit link-control word, a 6-bit scratch byte and the 0x3EED enable mask. With these values every one of the 512 offsets can be read and written in a few thousand clocks. This makes the zero-read and ignored-write rules checkable at every offset, not just a sample. The same small window allows all 256 status and scratch values, on both mirrors, to be compared against an arithmetic model kept in the bench. All four combinations of interrupt level and device presence are also covered.

// File: rtl/dcsc_pkg.sv
package dcsc_pkg;

  localparam int NUM_CH = 2;

  // Window layout (behavioural: software depends on these offsets)
  localparam int BM_STRIDE   = 8;
  localparam int BM_MIRROR   = 'h10;
  localparam int SUM_BASE    = 'h10;
  localparam int CONF_BASE   = 'hA0;
  localparam int CONF_STRIDE = 'h40;
  localparam int LNK_BASE    = 'h100;
  localparam int LNK_STRIDE  = 'h80;
  localparam int LSTAT_OFF   = 4;
  localparam int IEN_OFF     = 'h48;

  typedef enum logic [3:0] {
    RK_ZERO, RK_CMD, RK_SW, RK_ST, RK_SUM,
    RK_CONF, RK_LNK, RK_LSTAT, RK_IEN
  } rd_kind_e;

  // Next value of a status byte.
  function automatic logic [7:0] stat_next(input logic [7:0] old,
                                           input logic       wr,
                                           input logic [7:0] wd,
                                           input logic       act,
                                           input logic [1:0] set);
    logic [7:0] n;
    logic [1:0] clr;
    clr    = wr ? wd[2:1] : 2'b00;
    n      = '0;
    n[0]   = act;
    n[2:1] = (old[2:1] & ~clr) | set;
    n[6:5] = wr ? wd[6:5] : old[6:5];
    return n;
  endfunction

  // Packed summary word seen at channel 0's summary offset.
  function automatic logic [31:0] summary_ch0(input logic [7:0] cmd0,
                                              input logic [7:0] st0,
                                              input logic [7:0] st1,
                                              input logic       f0,
                                              input logic       f1);
    logic [31:0] w;
    w        = {st1, st0, 8'h00, cmd0};
    w[4]     = w[4] | f0;
    w[6]     = w[6] | f1;
    w[14]    = st1[2];
    return w;
  endfunction

  // Summary word seen at channel 1's summary offset.
  function automatic logic [31:0] summary_ch1(input logic [7:0] cmd1,
                                              input logic [7:0] st1,
                                              input logic       f1);
    logic [31:0] w;
    w    = {8'h00, st1, 8'h00, cmd1};
    w[4] = w[4] | f1;
    return w;
  endfunction

  function automatic logic [31:0] conf_word(input logic [15:0] id,
                                            input logic        flag);
    return {id, 4'h0, flag, 11'h000};
  endfunction

  function automatic logic [31:0] size_trim(input logic [1:0]  sz,
                                            input logic [31:0] v);
    case (sz)
      2'd0:    return {24'h0, v[7:0]};
      2'd1:    return {16'h0, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/dcsc_addr_decode.sv
module dcsc_addr_decode
  import dcsc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] w_cmd,
  output logic [NUM_CH-1:0] w_sw,
  output logic [NUM_CH-1:0] w_st,
  output logic [NUM_CH-1:0] w_lnk,
  output logic [NUM_CH-1:0] w_ien,
  output rd_kind_e          rkind,
  output logic              rch
);

  always_comb begin
    w_cmd = '0;
    w_sw  = '0;
    w_st  = '0;
    w_lnk = '0;
    w_ien = '0;
    rkind = RK_ZERO;
    rch   = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      // bus-master bytes and their write-only mirrors
      for (int m = 0; m < 2; m++) begin
        if (addr == ADDR_W'(c*BM_STRIDE + m*BM_MIRROR + 0)) w_cmd[c] = 1'b1;
        if (addr == ADDR_W'(c*BM_STRIDE + m*BM_MIRROR + 1)) w_sw[c]  = 1'b1;
        if (addr == ADDR_W'(c*BM_STRIDE + m*BM_MIRROR + 2)) w_st[c]  = 1'b1;
      end
      if (addr == ADDR_W'(LNK_BASE + c*LNK_STRIDE))           w_lnk[c] = 1'b1;
      if (addr == ADDR_W'(LNK_BASE + c*LNK_STRIDE + IEN_OFF)) w_ien[c] = 1'b1;

      if (addr == ADDR_W'(c*BM_STRIDE + 0)) begin rkind = RK_CMD; rch = c[0]; end
      if (addr == ADDR_W'(c*BM_STRIDE + 1)) begin rkind = RK_SW;  rch = c[0]; end
      if (addr == ADDR_W'(c*BM_STRIDE + 2)) begin rkind = RK_ST;  rch = c[0]; end
      if (addr == ADDR_W'(SUM_BASE + c*BM_STRIDE)) begin rkind = RK_SUM; rch = c[0]; end
      if (addr == ADDR_W'(CONF_BASE + c*CONF_STRIDE)) begin rkind = RK_CONF; rch = c[0]; end
      if (addr == ADDR_W'(LNK_BASE + c*LNK_STRIDE)) begin rkind = RK_LNK; rch = c[0]; end
      if (addr == ADDR_W'(LNK_BASE + c*LNK_STRIDE + LSTAT_OFF)) begin
        rkind = RK_LSTAT; rch = c[0];
      end
      if (addr == ADDR_W'(LNK_BASE + c*LNK_STRIDE + IEN_OFF)) begin
        rkind = RK_IEN; rch = c[0];
      end
    end
  end

endmodule

// File: rtl/dcsc_chan_regs.sv
module dcsc_chan_regs
  import dcsc_pkg::*;
#(
  parameter int          LNK_W    = 12,
  parameter int          SW_W     = 6,
  parameter logic [15:0] IEN_MASK = 16'h3EED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic             wr_sw,
  input  logic             wr_st,
  input  logic             wr_lnk,
  input  logic             wr_ien,
  input  logic [31:0]      wdata,
  input  logic             irq_level,
  input  logic             eng_active,
  input  logic [1:0]       eng_set,
  output logic [7:0]       cmd_q,
  output logic [SW_W-1:0]  sw_q,
  output logic [7:0]       st_q,
  output logic [LNK_W-1:0] lnk_q,
  output logic [15:0]      ien_q,
  output logic             flag_q,
  output logic             lnk_rst_req
);

  logic [7:0] st_d;

  assign st_d        = stat_next(st_q, wr_st, wdata[7:0], eng_active, eng_set);
  assign lnk_rst_req = wr_lnk & wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      sw_q   <= '0;
      st_q   <= '0;
      lnk_q  <= '0;
      ien_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= wdata[7:0];
      if (wr_sw)  sw_q  <= wdata[SW_W-1:0];
      if (wr_lnk) lnk_q <= wdata[LNK_W-1:0];
      if (wr_ien) ien_q <= wdata[31:16] & IEN_MASK;
      st_q   <= st_d;
      flag_q <= irq_level;
    end
  end

  AST_ST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && wdata[1] && !eng_set[0]) |=> !st_q[1]); // R4
  AST_ST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set[1] |=> st_q[2]); // R4
  AST_ST_BIT0_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> (st_q[0] == $past(eng_active))); // R4
  AST_SW_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw |=> (sw_q == $past(wdata[SW_W-1:0]))); // R5
  AST_IEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> ((ien_q & ~IEN_MASK) == 16'h0)); // R11
  AST_LNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lnk |=> $stable(lnk_q)); // R10
  AST_FLAG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_q == $past(irq_level))); // R8

endmodule

// File: rtl/dcsc_read_mux.sv
module dcsc_read_mux
  import dcsc_pkg::*;
#(
  parameter int          LNK_W      = 12,
  parameter int          SW_W       = 6,
  parameter logic [15:0] CONF_ID    = 16'h6515,
  parameter logic [11:0] LSTAT_CODE = 12'h113
) (
  input  rd_kind_e                      rkind,
  input  logic                          rch,
  input  logic [1:0]                    size,
  input  logic [NUM_CH-1:0][7:0]        cmd,
  input  logic [NUM_CH-1:0][SW_W-1:0]   sw,
  input  logic [NUM_CH-1:0][7:0]        st,
  input  logic [NUM_CH-1:0][LNK_W-1:0]  lnk,
  input  logic [NUM_CH-1:0][15:0]       ien,
  input  logic [NUM_CH-1:0]             flag,
  input  logic [NUM_CH-1:0]             present,
  output logic [31:0]                   value
);

  logic [31:0] raw;

  always_comb begin
    raw = '0;
    case (rkind)
      RK_CMD:   raw = {24'h0, cmd[rch]};
      RK_SW:    raw = 32'(sw[rch]);
      RK_ST:    raw = {24'h0, st[rch]};
      RK_SUM:   raw = rch ? summary_ch1(cmd[1], st[1], flag[1])
                          : summary_ch0(cmd[0], st[0], st[1], flag[0], flag[1]);
      RK_CONF:  raw = conf_word(CONF_ID, flag[rch]);
      RK_LNK:   raw = 32'(lnk[rch]);
      RK_LSTAT: raw = present[rch] ? 32'(LSTAT_CODE) : 32'h0;
      RK_IEN:   raw = {ien[rch], 16'h0};
      default:  raw = '0;
    endcase
    value = size_trim(size, raw);
  end

endmodule

// File: rtl/dcsc_regbank.sv
module dcsc_regbank
  import dcsc_pkg::*;
#(
  parameter int          ADDR_W     = 9,
  parameter int          LNK_W      = 12,
  parameter int          SW_W       = 6,
  parameter logic [15:0] IEN_MASK   = 16'h3EED,
  parameter logic [15:0] CONF_ID    = 16'h6515,
  parameter logic [11:0] LSTAT_CODE = 12'h113
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        irq_level,
  input  logic [1:0]        dev_present,
  input  logic [1:0]        eng_active,
  input  logic [3:0]        eng_set,
  output logic [31:0]       rd_data,
  output logic [1:0]        bus_reset,
  output logic              irq_out
);

  logic [NUM_CH-1:0] d_cmd, d_sw, d_st, d_lnk, d_ien;
  rd_kind_e          rkind;
  logic              rch;

  logic                         wr_en;
  logic                         rd_en;
  logic [NUM_CH-1:0][7:0]       cmd_q;
  logic [NUM_CH-1:0][SW_W-1:0]  sw_q;
  logic [NUM_CH-1:0][7:0]       st_q;
  logic [NUM_CH-1:0][LNK_W-1:0] lnk_q;
  logic [NUM_CH-1:0][15:0]      ien_q;
  logic [NUM_CH-1:0]            flag_q;
  logic [NUM_CH-1:0]            lnk_rst_req;
  logic [31:0]                  rd_value;
  logic                         boot_q;
  logic [NUM_CH-1:0]            bus_reset_q;
  logic [31:0]                  rd_q;

  assign wr_en = req_valid &  req_write;
  assign rd_en = req_valid & ~req_write;

  dcsc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .w_cmd (d_cmd),
    .w_sw  (d_sw),
    .w_st  (d_st),
    .w_lnk (d_lnk),
    .w_ien (d_ien),
    .rkind (rkind),
    .rch   (rch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcsc_chan_regs #(
      .LNK_W    (LNK_W),
      .SW_W     (SW_W),
      .IEN_MASK (IEN_MASK)
    ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_cmd      (wr_en & d_cmd[c]),
      .wr_sw       (wr_en & d_sw[c]),
      .wr_st       (wr_en & d_st[c]),
      .wr_lnk      (wr_en & d_lnk[c]),
      .wr_ien      (wr_en & d_ien[c]),
      .wdata       (req_wdata),
      .irq_level   (irq_level[c]),
      .eng_active  (eng_active[c]),
      .eng_set     (eng_set[2*c +: 2]),
      .cmd_q       (cmd_q[c]),
      .sw_q        (sw_q[c]),
      .st_q        (st_q[c]),
      .lnk_q       (lnk_q[c]),
      .ien_q       (ien_q[c]),
      .flag_q      (flag_q[c]),
      .lnk_rst_req (lnk_rst_req[c])
    );

    AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_q[c] |-> ($past(lnk_rst_req[c]) || $past(boot_q))); // R10
  end

  dcsc_read_mux #(
    .LNK_W      (LNK_W),
    .SW_W       (SW_W),
    .CONF_ID    (CONF_ID),
    .LSTAT_CODE (LSTAT_CODE)
  ) u_rmux (
    .rkind   (rkind),
    .rch     (rch),
    .size    (req_size),
    .cmd     (cmd_q),
    .sw      (sw_q),
    .st      (st_q),
    .lnk     (lnk_q),
    .ien     (ien_q),
    .flag    (flag_q),
    .present (dev_present),
    .value   (rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q      <= 1'b1;
      bus_reset_q <= '0;
      rd_q        <= '0;
    end else begin
      boot_q      <= 1'b0;
      bus_reset_q <= lnk_rst_req | {NUM_CH{boot_q}};
      if (rd_en) rd_q <= rd_value;
    end
  end

  assign rd_data   = rd_q;
  assign bus_reset = bus_reset_q;
  assign irq_out   = |flag_q;

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n || boot_q)
    irq_out == $past(|irq_level)); // R9
  AST_BOOT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> (bus_reset == 2'b11)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R14

endmodule

// File: tb/dcsc_regbank_tb.sv
`timescale 1ns/1ps
module dcsc_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic [1:0]  irq_level = '0;
  logic [1:0]  dev_present = '0;
  logic [1:0]  eng_active = '0;
  logic [3:0]  eng_set = '0;
  logic [31:0] rd_data;
  logic [1:0]  bus_reset;
  logic        irq_out;

  int n_run = 0;
  int n_fail = 0;

  // bench model
  logic [7:0]  m_cmd [2];
  logic [7:0]  m_sw  [2];
  logic [7:0]  m_st  [2];
  logic [11:0] m_lnk [2];
  logic [15:0] m_ien [2];
  logic [1:0]  m_flag;

  always #2.5 clk = ~clk;

  dcsc_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .irq_level(irq_level), .dev_present(dev_present), .eng_active(eng_active),
    .eng_set(eng_set), .rd_data(rd_data), .bus_reset(bus_reset), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] v;
    v = 0;
    case (a)
      'h000: v = m_cmd[0];
      'h001: v = m_sw[0];
      'h002: v = m_st[0];
      'h008: v = m_cmd[1];
      'h009: v = m_sw[1];
      'h00A: v = m_st[1];
      'h010: v = (m_cmd[0] | (32'(m_flag[0]) * 16) | (32'(m_flag[1]) * 64))
                 + (32'(m_st[1][2]) * 16384) + (32'(m_st[0]) * 65536)
                 + (32'(m_st[1]) * 16777216);
      'h018: v = (m_cmd[1] | (32'(m_flag[1]) * 16)) + 32'(m_st[1]) * 65536;
      'h0A0: v = 32'h6515_0000 + 32'(m_flag[0]) * 2048;
      'h0E0: v = 32'h6515_0000 + 32'(m_flag[1]) * 2048;
      'h100: v = m_lnk[0];
      'h180: v = m_lnk[1];
      'h104: v = dev_present[0] ? 32'h113 : 0;
      'h184: v = dev_present[1] ? 32'h113 : 0;
      'h148: v = 32'(m_ien[0]) * 65536;
      'h1C8: v = 32'(m_ien[1]) * 65536;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic bit writable(input int a);
    case (a)
      'h000, 'h001, 'h002, 'h008, 'h009, 'h00A,
      'h010, 'h011, 'h012, 'h018, 'h019, 'h01A,
      'h100, 'h148, 'h180, 'h1C8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    int ch;
    int off;
    ch  = (a % 16) / 8;
    off = a % 8;
    if (a < 'h20) begin
      if (off == 0) m_cmd[ch] = d[7:0];
      if (off == 1) m_sw[ch]  = d[7:0] % 64;
      if (off == 2) m_st[ch]  = (d[7:0] & 8'h60) | (m_st[ch] & 8'h01)
                                | (m_st[ch] & ~d[7:0] & 8'h06);
    end
    if (a == 'h100) m_lnk[0] = d[11:0];
    if (a == 'h180) m_lnk[1] = d[11:0];
    if (a == 'h148) m_ien[0] = d[31:16] & 16'h3EED;
    if (a == 'h1C8) m_ien[1] = d[31:16] & 16'h3EED;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = 9'(a); req_wdata = d; req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (writable(a)) model_write(a, d);
  endtask

  task automatic rd(input int a, input logic [1:0] sz, output logic [31:0] q);
    req_valid = 1'b1; req_write = 1'b0;
    req_addr = 9'(a); req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    q = rd_data;
  endtask

  task automatic eng_pulse(input int ch, input logic [1:0] bits);
    eng_set = '0;
    eng_set[2*ch +: 2] = bits;
    @(negedge clk);
    eng_set = '0;
    m_st[ch][2:1] = m_st[ch][2:1] | bits;
  endtask

  task automatic sweep_all(input string req);
    logic [31:0] q;
    for (int a = 0; a < 512; a++) begin
      rd(a, 2'd2, q);
      chk(req, q, exp_read(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] q;
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_sw[c] = 0; m_st[c] = 0; m_lnk[c] = 0; m_ien[c] = 0;
    end
    m_flag = 0;

    // R1: reset state and boot pulse
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 0);
    chk("R1 bus_reset in reset", 32'(bus_reset), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 boot pulse", 32'(bus_reset), 3);
    @(negedge clk);
    chk("R1 boot pulse ends", 32'(bus_reset), 0);
    chk("R1 irq_out", 32'(irq_out), 0);
    sweep_all("R1 R13 reset-state window sweep");

    // R2 R3 R5: scratch and command through both mirrors
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 2; c++) begin
        wr(c*8 + 1 + ((v % 2) * 16), 32'(v) ^ 32'h0000_5A00);
        rd(c*8 + 1, 2'd0, q);
        chk("R5 scratch low 6 bits", q, 32'(v % 64));
        wr(c*8 + (((v + 1) % 2) * 16), 32'(255 - v));
        rd(c*8, 2'd0, q);
        chk("R2 R3 command byte", q, 32'(255 - v));
      end
    end

    // R4: status rule, with engine set strobes
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 2; c++) begin
        if (v % 3 == 0) eng_pulse(c, 2'(v / 3));
        wr(c*8 + 2 + ((v % 2) * 16), 32'(v));
        rd(c*8 + 2, 2'd0, q);
        chk("R4 status write", q, 32'(m_st[c]));
      end
    end
    // R4: set wins over a same-cycle clear
    eng_set = 4'b0011;
    wr('h02, 32'h06);
    eng_set = '0;
    m_st[0][2:1] = 2'b11;
    rd('h02, 2'd0, q);
    chk("R4 set beats clear", q, 32'(m_st[0]));
    // R4: bit 0 follows engine activity, not writes
    eng_active = 2'b01;
    wr('h02, 32'h00);
    m_st[0][0] = 1'b1;
    rd('h02, 2'd0, q);
    chk("R4 bit0 follows engine", q, 32'(m_st[0]));
    eng_active = 2'b00;
    @(negedge clk);
    m_st[0][0] = 1'b0;
    rd('h02, 2'd0, q);
    chk("R4 bit0 drops with engine", q, 32'(m_st[0]));

    // R10: link control and reset pulse
    for (int c = 0; c < 2; c++) begin
      wr('h100 + c*'h80, 32'hFFFF_F5A4);
      chk("R10 no pulse for bit0=0", 32'(bus_reset), 0);
      wr('h100 + c*'h80, 32'h0000_1235);
      chk("R10 pulse after write", 32'(bus_reset), 32'(1 << c));
      @(negedge clk);
      chk("R10 pulse one cycle", 32'(bus_reset), 0);
      rd('h100 + c*'h80, 2'd2, q);
      chk("R10 link word 12 bits", q, 32'h235);
    end

    // R11: interrupt enable, walking ones and all-ones
    for (int b = 0; b < 17; b++) begin
      for (int c = 0; c < 2; c++) begin
        wr('h148 + c*'h80, (b == 16) ? 32'hFFFF_FFFF : (32'h1 << (16 + b)) | 32'h0000_FFFF);
        rd('h148 + c*'h80, 2'd2, q);
        chk("R11 enable field", q, 32'(m_ien[c]) * 65536);
      end
    end

    // R6 R7 R8 R9 R12: interrupt levels and device presence
    for (int p = 0; p < 4; p++) begin
      irq_level = 2'(p);
      dev_present = 2'(3 - p);
      @(negedge clk);
      m_flag = 2'(p);
      chk("R9 irq_out", 32'(irq_out), 32'(p != 0));
      rd('h10, 2'd2, q); chk("R6 summary ch0", q, exp_read('h10));
      rd('h18, 2'd2, q); chk("R7 summary ch1", q, exp_read('h18));
      rd('hA0, 2'd2, q); chk("R8 conf ch0", q, exp_read('hA0));
      rd('hE0, 2'd2, q); chk("R8 conf ch1", q, exp_read('hE0));
      rd('h104, 2'd2, q); chk("R12 link status ch0", q, exp_read('h104));
      rd('h184, 2'd2, q); chk("R12 link status ch1", q, exp_read('h184));
    end

    // R14: size trimming and hold
    rd('h10, 2'd0, q); chk("R14 byte read", q, exp_read('h10) & 32'hFF);
    rd('h10, 2'd1, q); chk("R14 half read", q, exp_read('h10) & 32'hFFFF);
    rd('h10, 2'd3, q); chk("R14 word read", q, exp_read('h10));
    wr('h001, 32'h3);
    chk("R14 hold across write", rd_data, exp_read('h10));

    // R8 R13: writes to read-only and unmapped offsets change nothing
    for (int a = 0; a < 512; a++) begin
      if (!writable(a)) begin
        wr(a, 32'hFFFF_FFFF);
        if (bus_reset != 0) chk("R13 no pulse on unmapped write", 32'(bus_reset), 0);
      end
    end
    n_run++;
    sweep_all("R8 R13 window after unmapped writes");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule